// File: doc/BRIEF.md
# Bidirectional Port with Buzzer and Divider Routing

This block gives a small microcontroller one 8-bit bidirectional I/O port (port A) and one 6-bit input-only port (port B), both reached through a byte-wide register bus. Writes to port A go into an output latch that keeps its value until it is written again. Reads of either port return the live pad levels captured at the read strobe, never the latch contents. A read-modify-write sequence therefore picks up whatever a floating or loaded line shows at that moment.

Each of the low four port-A bits can be set by a static option to push-pull or to open-drain with an optional pull-up. The upper four bits are always open-drain with a pull-up. An open-drain bit can only pull its line low: a latch value of 1 releases the line so that it can serve as an input. When both PA0 and PA1 are push-pull and the buzzer option is on, the two pads carry a complementary tone pair, and the PA0 and PA1 latch bits select which tone outputs are active. When PA3 is push-pull and the divider option is on, PA3 carries the divider output. A released open-drain line that has its wake enable set raises a one-cycle wake request when its level falls.

The pad model is left to the surrounding logic. Per-bit output enable, output value and pull-up enable leave the block, and the resolved pad levels come back in.

Top module: `pio_buzzer_port`

## Requirements
- R1: After reset the port-A latch is 8'hFF. Every open-drain bit then has its output enable at 0, and a push-pull bit without buzzer or divider routing drives 1.
- R2: A write with address 0x12 loads wr_data into the port-A latch, and the latch keeps that value until the next write to 0x12. A write to any other address leaves the latch and the pad outputs unchanged.
- R3: A read at address 0x12 captures pa_pad_in at the clock edge where rd_en is high. The value appears on rd_data after that edge and holds until the next read, even when it differs from the latch and even when the pads change afterwards.
- R4: A read at address 0x14 returns {2'b00, pb_pad_in}. A read at any other address returns 0.
- R5: A push-pull bit (bits 0 to 3 with opt_push_pull set) has pa_oe=1 and pa_pu=0. Unless buzzer or divider routing applies, pa_out equals its latch bit.
- R6: An open-drain bit has pa_out=0 and pa_oe equal to the inverse of its latch bit. For bits 0 to 3, pa_pu equals opt_pullup. Bits 4 to 7 are always open-drain with pa_pu=1, whatever the options say.
- R7: The buzzer routing is active when opt_buzz_en=1 and bits 0 and 1 are both push-pull. With latch bit0=1, both pads drive 0. With latch bit1=0 and bit0=0, PA0 drives buzz_in and PA1 drives its inverse. With latch bit1=1 and bit0=0, PA0 drives buzz_in and PA1 drives 0. When the routing is inactive, bits 0 and 1 behave as in R5 and R6.
- R8: When opt_div_en=1 and bit 3 is push-pull, pa_out[3] equals div_in. Otherwise bit 3 follows R5 or R6.
- R9: A bit is eligible for wake-up when opt_wake_en is set for it, it is open-drain and its latch bit is 1. The pad input passes through a two-stage synchronizer. A 1-to-0 change on an eligible bit raises wake_req for exactly one cycle, after the second rising edge that follows the pad change. Falls on bits that are not eligible, and rising edges, produce no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data captured at the last read |
| opt_push_pull | input | 4 | Per-bit push-pull select for port-A bits 0 to 3 |
| opt_pullup | input | 4 | Per-bit pull-up enable for open-drain bits 0 to 3 |
| opt_buzz_en | input | 1 | Routes the tone pair to PA0 and PA1 |
| opt_div_en | input | 1 | Routes the divider output to PA3 |
| opt_wake_en | input | 8 | Per-bit wake-up enable |
| buzz_in | input | 1 | Tone waveform from the buzzer generator |
| div_in | input | 1 | Divider output waveform |
| pa_pad_in | input | 8 | Resolved port-A pad levels |
| pb_pad_in | input | 6 | Port-B pad levels |
| pa_oe | output | 8 | Port-A per-bit output enable |
| pa_out | output | 8 | Port-A per-bit output value |
| pa_pu | output | 8 | Port-A per-bit pull-up enable |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
The bench pulls port-A lines low from outside while the latch holds 1s. A design that read the latch instead of the pads would return 0xFF there, and one that did not hold the captured byte would follow later pad changes. It walks all three buzzer latch codes with both tone levels. It also drops push-pull from PA1, so a design that keyed the routing on the buzzer option alone would still emit tones. The wake test times the request to the exact cycle and drives falls on a bit that has no wake enable and on rising edges. An unsynchronized, level-sensitive or wrongly masked detector would fire early, stay high or fire on the wrong line.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [1:0] {
    BZ_PAIR   = 2'd0,
    BZ_SINGLE = 2'd1,
    BZ_MUTE   = 2'd2
  } bz_mode_e;

  function automatic bz_mode_e bz_decode(input logic l1, input logic l0);
    if (l0) return BZ_MUTE;
    else if (l1) return BZ_SINGLE;
    else return BZ_PAIR;
  endfunction

  // returns {pa1, pa0}
  function automatic logic [1:0] bz_drive(input bz_mode_e m, input logic tone);
    case (m)
      BZ_PAIR:   return {~tone, tone};
      BZ_SINGLE: return {1'b0, tone};
      default:   return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/pio_regs.sv
module pio_regs #(
  parameter int AW = 8,
  parameter int PA_W = 8,
  parameter int PB_W = 6,
  parameter logic [AW-1:0] PA_ADDR = 'h12,
  parameter logic [AW-1:0] PB_ADDR = 'h14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic [PA_W-1:0] wr_data,
  input  logic            rd_en,
  input  logic [PA_W-1:0] pa_pad_in,
  input  logic [PB_W-1:0] pb_pad_in,
  output logic [PA_W-1:0] pa_latch,
  output logic [PA_W-1:0] rd_data
);

  logic pa_wr_hit, pa_rd_hit, pb_rd_hit;
  logic [PA_W-1:0] pb_ext;
  logic [PA_W-1:0] rd_mux;

  assign pa_wr_hit = wr_en && (addr == PA_ADDR);
  assign pa_rd_hit = rd_en && (addr == PA_ADDR);
  assign pb_rd_hit = rd_en && (addr == PB_ADDR);
  assign pb_ext    = PA_W'(pb_pad_in);

  always_comb begin
    if (pa_rd_hit)      rd_mux = pa_pad_in;
    else if (pb_rd_hit) rd_mux = pb_ext;
    else                rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pa_latch <= '1;
    else if (pa_wr_hit) pa_latch <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pa_wr_hit |=> $stable(pa_latch));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R4
  pb_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pb_rd_hit |=> (rd_data >> PB_W) == '0);

endmodule

// File: rtl/pio_drive.sv
module pio_drive
  import pio_pkg::*;
#(
  parameter int PA_W = 8,
  parameter int PP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PA_W-1:0] pa_latch,
  input  logic [PP_W-1:0] opt_push_pull,
  input  logic [PP_W-1:0] opt_pullup,
  input  logic            opt_buzz_en,
  input  logic            opt_div_en,
  input  logic            buzz_in,
  input  logic            div_in,
  output logic [PA_W-1:0] pa_oe,
  output logic [PA_W-1:0] pa_out,
  output logic [PA_W-1:0] pa_pu,
  output logic [PA_W-1:0] od_mask
);

  localparam int DIV_BIT = 3;

  logic [PA_W-1:0] pp_eff;
  logic [PA_W-1:0] pu_opt;
  logic [PA_W-1:0] pp_val;
  logic            buzz_active, div_active;
  logic [1:0]      buzz_pair;
  bz_mode_e        bz_mode;

  genvar i;
  generate
    for (i = 0; i < PA_W; i++) begin : g_bit
      if (i < PP_W) begin : g_cfg
        assign pp_eff[i] = opt_push_pull[i];
        assign pu_opt[i] = opt_pullup[i];
      end else begin : g_fixed
        assign pp_eff[i] = 1'b0;
        assign pu_opt[i] = 1'b1;
      end
    end
  endgenerate

  assign buzz_active = opt_buzz_en && pp_eff[0] && pp_eff[1];
  assign div_active  = opt_div_en && pp_eff[DIV_BIT];
  assign bz_mode     = bz_decode(pa_latch[1], pa_latch[0]);
  assign buzz_pair   = bz_drive(bz_mode, buzz_in);

  always_comb begin
    pp_val = pa_latch;
    if (buzz_active) pp_val[1:0] = buzz_pair;
    if (div_active)  pp_val[DIV_BIT] = div_in;
  end

  assign od_mask = ~pp_eff;
  assign pa_oe   = pp_eff | ~pa_latch;
  assign pa_out  = pp_eff & pp_val;
  assign pa_pu   = od_mask & pu_opt;

  // R6
  od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (od_mask & pa_out) == '0);

  // R7
  buzz_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buzz_active && pa_latch[0]) |-> pa_out[1:0] == 2'b00);

  // R7
  buzz_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buzz_active && pa_latch[1:0] == 2'b00) |-> pa_out[1] != pa_out[0]);

  // R5
  pp_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_oe | od_mask) == '1);

endmodule

// File: rtl/pio_wake.sv
module pio_wake #(
  parameter int PA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PA_W-1:0] pa_pad_in,
  input  logic [PA_W-1:0] od_mask,
  input  logic [PA_W-1:0] pa_latch,
  input  logic [PA_W-1:0] opt_wake_en,
  output logic            wake_req
);

  logic [PA_W-1:0] sync_q [SYNC_STAGES];
  logic [PA_W-1:0] prev_q;
  logic [PA_W-1:0] elig;
  logic [PA_W-1:0] fall_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= '1;
    else        sync_q[0] <= pa_pad_in;
  end

  genvar s;
  generate
    for (s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= '1;
        else        sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign elig     = opt_wake_en & od_mask & pa_latch;
  assign fall_vec = elig & prev_q & ~sync_q[SYNC_STAGES-1];
  assign wake_req = |fall_vec;

  // R9
  wake_low_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (elig & ~sync_q[SYNC_STAGES-1]) != '0);

  // R9
  wake_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q[SYNC_STAGES-1] == prev_q) |-> !wake_req);

endmodule

// File: rtl/pio_buzzer_port.sv
module pio_buzzer_port #(
  parameter int AW = 8,
  parameter int PA_W = 8,
  parameter int PB_W = 6,
  parameter int PP_W = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [AW-1:0] PA_ADDR = 'h12,
  parameter logic [AW-1:0] PB_ADDR = 'h14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic [PA_W-1:0] wr_data,
  input  logic            rd_en,
  output logic [PA_W-1:0] rd_data,
  input  logic [PP_W-1:0] opt_push_pull,
  input  logic [PP_W-1:0] opt_pullup,
  input  logic            opt_buzz_en,
  input  logic            opt_div_en,
  input  logic [PA_W-1:0] opt_wake_en,
  input  logic            buzz_in,
  input  logic            div_in,
  input  logic [PA_W-1:0] pa_pad_in,
  input  logic [PB_W-1:0] pb_pad_in,
  output logic [PA_W-1:0] pa_oe,
  output logic [PA_W-1:0] pa_out,
  output logic [PA_W-1:0] pa_pu,
  output logic            wake_req
);

  logic [PA_W-1:0] pa_latch;
  logic [PA_W-1:0] od_mask;

  pio_regs #(
    .AW(AW), .PA_W(PA_W), .PB_W(PB_W), .PA_ADDR(PA_ADDR), .PB_ADDR(PB_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .pa_pad_in(pa_pad_in), .pb_pad_in(pb_pad_in),
    .pa_latch(pa_latch), .rd_data(rd_data)
  );

  pio_drive #(.PA_W(PA_W), .PP_W(PP_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .pa_latch(pa_latch),
    .opt_push_pull(opt_push_pull), .opt_pullup(opt_pullup),
    .opt_buzz_en(opt_buzz_en), .opt_div_en(opt_div_en),
    .buzz_in(buzz_in), .div_in(div_in),
    .pa_oe(pa_oe), .pa_out(pa_out), .pa_pu(pa_pu), .od_mask(od_mask)
  );

  pio_wake #(.PA_W(PA_W), .SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk(clk), .rst_n(rst_n), .pa_pad_in(pa_pad_in), .od_mask(od_mask),
    .pa_latch(pa_latch), .opt_wake_en(opt_wake_en), .wake_req(wake_req)
  );

  // R1
  reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pa_oe & od_mask) == '0);

endmodule

// File: tb/pio_buzzer_port_tb.sv
module pio_buzzer_port_tb;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] addr = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic       rd_en = 0;
  logic [7:0] rd_data;
  logic [3:0] opt_push_pull = 0;
  logic [3:0] opt_pullup = 4'hF;
  logic       opt_buzz_en = 0;
  logic       opt_div_en = 0;
  logic [7:0] opt_wake_en = 0;
  logic       buzz_in = 0;
  logic       div_in = 0;
  logic [7:0] pa_pad_in;
  logic [5:0] pb_pad_in = 0;
  logic [7:0] pa_oe, pa_out, pa_pu;
  logic       wake_req;

  logic [7:0] ext_en = 0;
  logic [7:0] ext_val = 0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // pad model: driver wins, then external source, then pull-up, else floats low
  always_comb
    for (int i = 0; i < 8; i++)
      pa_pad_in[i] = pa_oe[i] ? pa_out[i] : ext_en[i] ? ext_val[i] : pa_pu[i];

  pio_buzzer_port u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .opt_push_pull(opt_push_pull),
    .opt_pullup(opt_pullup), .opt_buzz_en(opt_buzz_en), .opt_div_en(opt_div_en),
    .opt_wake_en(opt_wake_en), .buzz_in(buzz_in), .div_in(div_in),
    .pa_pad_in(pa_pad_in), .pb_pad_in(pb_pad_in), .pa_oe(pa_oe),
    .pa_out(pa_out), .pa_pu(pa_pu), .wake_req(wake_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  // bench's own statement of the tone table, keyed on latch bits {b1,b0}
  function automatic logic [1:0] tone_pads(input logic [1:0] lat, input logic t);
    logic [1:0] r;
    r = 2'b00;
    if (lat == 2'b00) r = {!t, t};
    if (lat == 2'b10) r = {1'b0, t};
    return r;
  endfunction

  task automatic t_reset;
    logic [7:0] d;
    #1;
    chk("R1 oe after reset", pa_oe, 8'h00);
    chk("R6 pull-ups after reset", pa_pu, 8'hFF);
    rd(8'h12, d);
    chk("R1 pads high after reset", d, 8'hFF);
  endtask

  task automatic t_write_hold;
    wr(8'h12, 8'h5A); #1;
    chk("R2 R6 oe follows latch", pa_oe, 8'hA5);
    chk("R6 od out low", pa_out, 8'h00);
    wr(8'h13, 8'h00); #1;
    chk("R2 other address ignored", pa_oe, 8'hA5);
    repeat (3) @(negedge clk); #1;
    chk("R2 latch holds", pa_oe, 8'hA5);
  endtask

  task automatic t_read_pads;
    logic [7:0] d;
    wr(8'h12, 8'hFF);
    ext_en = 8'hF0; ext_val = 8'h30;
    rd(8'h12, d);
    chk("R3 read returns pads not latch", d, 8'h3F);
    ext_val = 8'hC0;
    repeat (2) @(negedge clk); #1;
    chk("R3 read data held", rd_data, 8'h3F);
    opt_pullup = 4'hE;
    rd(8'h12, d);
    chk("R3 floating bit reads low", d, 8'hCE);
    chk("R6 pull-up option", pa_pu, 8'hFE);
    opt_pullup = 4'hF; ext_en = 0;
  endtask

  task automatic t_pb;
    logic [7:0] d;
    pb_pad_in = 6'h2B;
    rd(8'h14, d);
    chk("R4 port B read", d, 8'h2B);
    pb_pad_in = 6'h3F;
    rd(8'h14, d);
    chk("R4 port B upper zero", d, 8'h3F);
    rd(8'h20, d);
    chk("R4 unmapped read zero", d, 8'h00);
  endtask

  task automatic t_push_pull;
    opt_push_pull = 4'hF;
    wr(8'h12, 8'hA5); #1;
    chk("R5 pp oe", pa_oe, 8'h5F);
    chk("R5 pp out", pa_out, 8'h05);
    chk("R5 R6 pp no pull-up", pa_pu, 8'hF0);
  endtask

  task automatic t_buzzer;
    logic [1:0] codes [3];
    codes[0] = 2'b00; codes[1] = 2'b10; codes[2] = 2'b01;
    opt_push_pull = 4'hF; opt_buzz_en = 1;
    for (int c = 0; c < 3; c++) begin
      wr(8'h12, {6'b000000, codes[c]});
      for (int t = 0; t < 2; t++) begin
        @(negedge clk); buzz_in = t[0]; #1;
        chk("R7 buzzer pads", pa_out[1:0], tone_pads(codes[c], t[0]));
      end
    end
    opt_push_pull = 4'hD;
    wr(8'h12, 8'h00);
    @(negedge clk); buzz_in = 1; #1;
    chk("R7 routing off when PA1 open-drain", pa_out[1:0], 2'b00);
    chk("R7 PA1 open-drain pulls low", pa_oe[1], 1'b1);
    opt_buzz_en = 0; opt_push_pull = 4'hF;
    wr(8'h12, 8'h01); #1;
    chk("R7 buzzer off follows latch", pa_out[1:0], 2'b01);
    buzz_in = 0;
  endtask

  task automatic t_divider;
    opt_push_pull = 4'h8; opt_div_en = 1;
    wr(8'h12, 8'hF7);
    @(negedge clk); div_in = 1; #1;
    chk("R8 divider high", pa_out[3], 1'b1);
    @(negedge clk); div_in = 0; #1;
    chk("R8 divider low", pa_out[3], 1'b0);
    wr(8'h12, 8'hFF);
    @(negedge clk); div_in = 0; #1;
    chk("R8 divider overrides latch", pa_out[3], 1'b0);
    opt_div_en = 0; #1;
    chk("R8 divider off follows latch", pa_out[3], 1'b1);
    opt_div_en = 1; opt_push_pull = 4'h0; div_in = 1;
    wr(8'h12, 8'hF7); #1;
    chk("R8 od bit ignores divider", {pa_oe[3], pa_out[3]}, 2'b10);
    opt_div_en = 0; div_in = 0;
  endtask

  task automatic t_wake;
    opt_push_pull = 0;
    wr(8'h12, 8'hFF);
    opt_wake_en = 8'h10; ext_en = 8'h30; ext_val = 8'h30;
    repeat (4) @(negedge clk);
    ext_val = 8'h20;
    @(posedge clk); #1; chk("R9 no request after one edge", wake_req, 1'b0);
    @(posedge clk); #1; chk("R9 request after second edge", wake_req, 1'b1);
    @(posedge clk); #1; chk("R9 request lasts one cycle", wake_req, 1'b0);
    @(negedge clk); ext_val = 8'h30;
    repeat (4) @(posedge clk); #1;
    chk("R9 rising edge ignored", wake_req, 1'b0);
    @(negedge clk); ext_val = 8'h10;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      chk("R9 disabled bit ignored", wake_req, 1'b0);
    end
    opt_wake_en = 0; ext_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_write_hold();
    t_read_pads();
    t_pb();
    t_push_pull();
    t_buzzer();
    t_divider();
    t_wake();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule